// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Engine

This block is a read-only master for serial NOR flash. It issues one of two fast read commands that use two data lanes. A single request gives a 24-bit start address, a byte count and a command choice. The engine then selects the flash, shifts out the command and address, and returns the requested bytes in address order as a stream on `rd_data`, with `rd_valid` marking each byte. The eight opcode clocks always use one lane. The clocks that follow use one lane or two, depending on the command.

With the dual-output command (3Bh), the address goes out one bit per clock on IO0. Eight dummy clocks follow, and then data comes back two bits per clock. With the dual-I/O command (BBh), the address and a mode byte go out two bits per clock on both lines. Data follows at once. The engine releases its drivers on both IO lines before the flash starts to drive them.

The serial clock idles low (SPI mode 0) and is derived from the system clock. Each half period lasts `sclk_div`+1 system cycles. The engine changes its outputs on the falling serial edge and samples inputs on the rising edge. Chip select stays low for the whole burst. `done` pulses when chip select goes high again, and the engine stays busy for a minimum chip-select-high time before it takes another request.

Top module: `dio_flash_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, both output enables are 0, and `busy`, `done` and `rd_valid` are all 0.
- R2: Each burst begins with eight serial clocks that carry the opcode on IO0, MSB first. The opcode is 3Bh when `cmd_sel`=0 and BBh when `cmd_sel`=1.
- R3: With `cmd_sel`=0, the 24 address bits go out on IO0, MSB first, one per clock (clocks 8 to 31). Eight dummy clocks follow, and the first data clock is clock 40.
- R4: With `cmd_sel`=1, address and then `mode_byte` go out two bits per clock over clocks 8 to 23. IO1 carries the odd bit and IO0 the even bit of each pair, highest pair first, and the first data clock is clock 24.
- R5: Each data byte takes four clocks. IO1 supplies D7, D5, D3, D1 and IO0 supplies D6, D4, D2, D0, highest pair first. Each byte appears on `rd_data` with `rd_valid` high for exactly one cycle, in increasing address order.
- R6: During the opcode clocks and the single-lane address, only IO0 is enabled. During the dual address and mode clocks both lines are enabled. From the first dummy clock (3Bh) or the first data clock (BBh) until `cs_n` rises, neither line is enabled, and neither is enabled while `cs_n` is high.
- R7: `sclk` is 0 whenever `cs_n` is 1. Each high phase of `sclk` lasts `sclk_div`+1 system cycles, with `sclk_div` captured when the request is accepted.
- R8: One burst holds `cs_n` low for one continuous interval. Within it come exactly header + 4×`nbytes` rising `sclk` edges (header 40 for 3Bh, 24 for BBh), and exactly `nbytes` bytes are delivered.
- R9: `done` is high for one cycle, in the cycle in which `cs_n` first reads 1 after the burst. `busy` is high from acceptance until `cs_n` has been high for CSH_MIN (default 4) cycles. A `req` while `busy` is high is ignored.
- R10: A `req` with `nbytes`=0 is ignored. No chip select activity follows, and neither `busy` nor `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, taken when idle |
| cmd_sel | input | 1 | 0: dual-output read, 1: dual-I/O read |
| addr | input | 24 | Start byte address |
| nbytes | input | LEN_W (8) | Number of bytes to read, 0 is ignored |
| mode_byte | input | 8 | Mode byte sent with dual-I/O reads, held static (00h) |
| sclk_div | input | DIV_W (4) | Serial half period minus one, in system cycles |
| busy | output | 1 | Burst or CS-high gap in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, mode 0 |
| io0_o | output | 1 | IO0 output value |
| io0_oe | output | 1 | IO0 output enable |
| io0_i | input | 1 | IO0 input value |
| io1_o | output | 1 | IO1 output value |
| io1_oe | output | 1 | IO1 output enable |
| io1_i | input | 1 | IO1 input value |

## Verification
The hardest point to reach is the handover of the IO lines. The bus has to change direction on the exact falling edge after the last address or dummy bit, while the flash model starts to drive on that same edge. The bench uses a behavioural flash that tracks its own clock index and flags any enabled master driver from the first clock that belongs to the flash. It runs both commands at several divider values, including zero, where the sample edge and the byte-boundary decision fall in adjacent system cycles. Requests made in the middle of a burst and during the chip-select-high gap cover the case where a request must be ignored.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  localparam logic [7:0] OP_DUAL_OUT = 8'h3B;
  localparam logic [7:0] OP_DUAL_IO  = 8'hBB;

  localparam int ADDR_W = 24;
  localparam int TX_W   = 8 + ADDR_W + 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } dfr_state_e;

endpackage

// File: rtl/dfr_sclk_gen.sv
module dfr_sclk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_tk,
  output logic             fall_tk
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             edge_now;

  assign edge_now = run && (cnt_q == div);
  assign rise_tk  = edge_now && !sclk_q;
  assign fall_tk  = edge_now &&  sclk_q;
  assign sclk     = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (edge_now) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/dfr_rx_pack.sv
module dfr_rx_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              lane_hi,
  input  logic              lane_lo,
  output logic              byte_end,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld
);

  localparam int PAIRS  = BYTE_W / 2;
  localparam int PCNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PCNT_W-1:0] pair_q, pair_d;
  logic [BYTE_W-3:0] sr_q, sr_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;

  assign byte_end = sample && (pair_q == PCNT_W'(PAIRS - 1));
  assign byte_o   = byte_q;
  assign byte_vld = vld_q;

  always_comb begin
    pair_d = pair_q;
    sr_d   = sr_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (sample) begin
      if (byte_end) begin
        byte_d = {sr_q, lane_hi, lane_lo};
        vld_d  = 1'b1;
        pair_d = '0;
      end else begin
        sr_d   = {sr_q[BYTE_W-5:0], lane_hi, lane_lo};
        pair_d = pair_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      sr_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      pair_q <= pair_d;
      sr_q   <= sr_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

endmodule

// File: rtl/dfr_seq.sv
module dfr_seq
  import dfr_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int CSH_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              cmd_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  nbytes,
  input  logic [7:0]        mode_byte,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              byte_end,
  output logic              accept,
  output logic              run,
  output logic              data_phase,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              io0_o,
  output logic              io0_oe,
  output logic              io1_o,
  output logic              io1_oe
);

  localparam int GAP_W = (CSH_MIN > 1) ? $clog2(CSH_MIN) : 1;

  dfr_state_e        st_q, st_d;
  logic [4:0]        pcnt_q, pcnt_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic              dual_q, dual_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              last_q, last_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [TX_W-1:0]   tx_sh1, tx_sh2;

  assign accept     = (st_q == ST_IDLE) && req && (nbytes != '0);
  assign run        = (st_q != ST_IDLE) && (st_q != ST_GAP);
  assign data_phase = (st_q == ST_DATA);
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign cs_n       = cs_n_q;
  assign tx_sh1     = {tx_q[TX_W-2:0], 1'b0};
  assign tx_sh2     = {tx_q[TX_W-3:0], 2'b00};

  // Lane drive: one lane for opcode and single-lane address, both for dual phases.
  always_comb begin
    io0_o  = 1'b0;
    io0_oe = 1'b0;
    io1_o  = 1'b0;
    io1_oe = 1'b0;
    case (st_q)
      ST_CMD: begin
        io0_o  = tx_q[TX_W-1];
        io0_oe = 1'b1;
      end
      ST_ADDR, ST_MODE: begin
        if (dual_q) begin
          io1_o  = tx_q[TX_W-1];
          io0_o  = tx_q[TX_W-2];
          io1_oe = 1'b1;
          io0_oe = 1'b1;
        end else begin
          io0_o  = tx_q[TX_W-1];
          io0_oe = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    tx_d   = tx_q;
    dual_d = dual_q;
    left_d = left_q;
    last_d = last_q;
    gap_d  = gap_q;
    cs_n_d = cs_n_q;
    done_d = 1'b0;

    if (byte_end) begin
      left_d = left_q - 1'b1;
      if (left_q == LEN_W'(1)) last_d = 1'b1;
    end

    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_CMD;
          pcnt_d = 5'd7;
          tx_d   = {(cmd_sel ? OP_DUAL_IO : OP_DUAL_OUT), addr, mode_byte};
          dual_d = cmd_sel;
          left_d = nbytes;
          last_d = 1'b0;
          cs_n_d = 1'b0;
        end
      end
      ST_CMD: begin
        if (fall_tk) begin
          tx_d = tx_sh1;
          if (pcnt_q == 5'd0) begin
            st_d   = ST_ADDR;
            pcnt_d = dual_q ? 5'd11 : 5'd23;
          end else begin
            pcnt_d = pcnt_q - 5'd1;
          end
        end
      end
      ST_ADDR: begin
        if (fall_tk) begin
          tx_d = dual_q ? tx_sh2 : tx_sh1;
          if (pcnt_q == 5'd0) begin
            st_d   = dual_q ? ST_MODE : ST_DUMMY;
            pcnt_d = dual_q ? 5'd3 : 5'd7;
          end else begin
            pcnt_d = pcnt_q - 5'd1;
          end
        end
      end
      ST_MODE: begin
        if (fall_tk) begin
          tx_d = tx_sh2;
          if (pcnt_q == 5'd0) st_d = ST_DATA;
          else                pcnt_d = pcnt_q - 5'd1;
        end
      end
      ST_DUMMY: begin
        if (fall_tk) begin
          if (pcnt_q == 5'd0) st_d = ST_DATA;
          else                pcnt_d = pcnt_q - 5'd1;
        end
      end
      ST_DATA: begin
        if (fall_tk && last_q) begin
          st_d   = ST_GAP;
          gap_d  = '0;
          cs_n_d = 1'b1;
          done_d = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_W'(CSH_MIN - 1)) st_d = ST_IDLE;
        else                              gap_d = gap_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      tx_q   <= '0;
      dual_q <= 1'b0;
      left_q <= '0;
      last_q <= 1'b0;
      gap_q  <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      tx_q   <= tx_d;
      dual_q <= dual_d;
      left_q <= left_d;
      last_q <= last_d;
      gap_q  <= gap_d;
      cs_n_q <= cs_n_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/dio_flash_reader.sv
module dio_flash_reader
  import dfr_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DIV_W   = 4,
  parameter int CSH_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              cmd_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  nbytes,
  input  logic [7:0]        mode_byte,
  input  logic [DIV_W-1:0]  sclk_div,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              cs_n,
  output logic              sclk,
  output logic              io0_o,
  output logic              io0_oe,
  input  logic              io0_i,
  output logic              io1_o,
  output logic              io1_oe,
  input  logic              io1_i
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_q, div_d;
  logic             accept, run, data_phase;
  logic             rise_tk, fall_tk, byte_end;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign div_d = accept ? sclk_div : div_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) div_q <= '0;
    else            div_q <= div_d;
  end

  dfr_seq #(
    .LEN_W   (LEN_W),
    .CSH_MIN (CSH_MIN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .cmd_sel    (cmd_sel),
    .addr       (addr),
    .nbytes     (nbytes),
    .mode_byte  (mode_byte),
    .rise_tk    (rise_tk),
    .fall_tk    (fall_tk),
    .byte_end   (byte_end),
    .accept     (accept),
    .run        (run),
    .data_phase (data_phase),
    .busy       (busy),
    .done       (done),
    .cs_n       (cs_n),
    .io0_o      (io0_o),
    .io0_oe     (io0_oe),
    .io1_o      (io1_o),
    .io1_oe     (io1_oe)
  );

  dfr_sclk_gen #(
    .DIV_W (DIV_W)
  ) u_sclk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .div     (div_q),
    .sclk    (sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  dfr_rx_pack #(
    .BYTE_W (8)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sample   (rise_tk && data_phase),
    .lane_hi  (io1_i),
    .lane_lo  (io0_i),
    .byte_end (byte_end),
    .byte_o   (rd_data),
    .byte_vld (rd_valid)
  );

endmodule

// File: rtl/dfr_chk.sv
module dfr_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic cs_n,
  input logic sclk,
  input logic io0_oe,
  input logic io1_oe
);

  // R6: IO1 is only ever driven together with IO0
  a_r6_io1_with_io0: assert property (@(posedge clk) disable iff (!rst_n)
    io1_oe |-> io0_oe);

  // R6: no driver while deselected
  a_r6_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(io0_oe || io1_oe));

  // R7: clock idles low outside a burst
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R5: each byte strobe lasts one cycle
  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R5: bytes only arrive inside a burst
  a_r5_valid_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);

  // R9: done coincides with chip select rising
  a_r9_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R9: done only while deselected and still busy
  a_r9_done_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && busy));

  // R9: selected implies busy
  a_r9_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dio_flash_reader dfr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .io0_oe   (io0_oe),
  .io1_oe   (io1_oe)
);

// File: tb/sim_dio_flash_reader.sv
module sim_dio_flash_reader;

  localparam int CLK_PERIOD = 10;
  localparam int GAP_CYC    = 4;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic        dual;
    logic [23:0] a;
    logic [7:0]  n;
    logic [3:0]  dv;
    logic [7:0]  m;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 24'h000000, 8'd3, 4'd1, 8'h00},
    '{1'b1, 24'hA5C3F1, 8'd5, 4'd0, 8'h20},
    '{1'b0, 24'hFFFFFE, 8'd4, 4'd2, 8'h00},
    '{1'b1, 24'h123456, 8'd1, 4'd3, 8'hA5},
    '{1'b1, 24'h800001, 8'd6, 4'd1, 8'h00},
    '{1'b0, 24'h5A5A5A, 8'd2, 4'd0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        cmd_sel = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  nbytes = '0;
  logic [7:0]  mode_byte = '0;
  logic [3:0]  sclk_div = '0;
  logic        busy, done, rd_valid, cs_n, sclk;
  logic [7:0]  rd_data;
  logic        io0_o, io0_oe, io1_o, io1_oe;
  logic        fio0 = 1'b0;
  logic        fio1 = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_flash_reader u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cmd_sel   (cmd_sel),
    .addr      (addr),
    .nbytes    (nbytes),
    .mode_byte (mode_byte),
    .sclk_div  (sclk_div),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .io0_o     (io0_o),
    .io0_oe    (io0_oe),
    .io0_i     (fio0),
    .io1_o     (io1_o),
    .io1_oe    (io1_oe),
    .io1_i     (fio1)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return {a[6:0], a[7]} ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // ---------------- behavioural flash ----------------
  int          k = 0;
  int          m_rises = 0;
  int          m_csf = 0;
  int          m_conf = 0;
  logic [7:0]  m_op = '0;
  logic [23:0] m_addr = '0;
  logic [7:0]  m_mode = '0;

  function automatic int first_rel(input logic [7:0] op);
    return (op == 8'h3B) ? 32 : 24;
  endfunction
  function automatic int first_dat(input logic [7:0] op);
    return (op == 8'h3B) ? 40 : 24;
  endfunction

  always @(negedge cs_n) begin
    k = 0; m_op = '0; m_addr = '0; m_mode = '0;
    m_csf++;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (k < 8) m_op = {m_op[6:0], io0_o};
      else if (m_op == 8'h3B) begin
        if (k < 32) m_addr = {m_addr[22:0], io0_o};
      end else begin
        if (k < 20)      m_addr = {m_addr[21:0], io1_o, io0_o};
        else if (k < 24) m_mode = {m_mode[5:0], io1_o, io0_o};
      end
      if (k >= 8 && k >= first_rel(m_op) && (io0_oe || io1_oe)) m_conf++;
      k++;
      m_rises++;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && k >= 8 && k >= first_dat(m_op)) begin
      int j, p;
      logic [7:0] b;
      j = (k - first_dat(m_op)) / 4;
      p = (k - first_dat(m_op)) % 4;
      b = fbyte(m_addr + 24'(j));
      fio1 = b[7-2*p];
      fio0 = b[6-2*p];
    end
  end

  // ---------------- output monitor ----------------
  logic [7:0] got [64];
  int nvalid = 0;
  int ndone = 0;
  int hi_run = 0;
  int hi_bad = 0;
  int hi_exp = 1;
  int gap_len = 0;

  always @(negedge clk) begin
    cyc++;
    if (rd_valid) begin
      if (nvalid < 64) got[nvalid] = rd_data;
      nvalid++;
    end
    if (done) ndone++;
    if (cs_n && busy) gap_len++;
    if (!cs_n && sclk) hi_run++;
    else begin
      if (hi_run > 0 && hi_run != hi_exp) hi_bad++;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nvalid = 0; ndone = 0; hi_bad = 0; gap_len = 0;
    m_rises = 0; m_csf = 0; m_conf = 0;
  endtask

  task automatic start(input logic d, input logic [23:0] a, input logic [7:0] n,
                       input logic [3:0] dv, input logic [7:0] m);
    @(negedge clk);
    cmd_sel = d; addr = a; nbytes = n; sclk_div = dv; mode_byte = m;
    hi_exp = int'(dv) + 1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (ndone == 0 && t < 20000) begin @(negedge clk); t++; end
    while (busy && t < 20000) begin @(negedge clk); t++; end
  endtask

  // watchdog
  initial begin
    while (cyc < 150000) @(negedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 cs/sclk", {cs_n, sclk}, 2'b10);
    chk(io0_oe === 1'b0 && io1_oe === 1'b0, "R1 oe", {io1_oe, io0_oe}, 0);
    chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R1 status",
        {busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      int mism = 0;
      int hdr;
      clear_mon();
      start(VEC[v].dual, VEC[v].a, VEC[v].n, VEC[v].dv, VEC[v].m);
      wait_idle();
      hdr = VEC[v].dual ? 24 : 40;
      chk(m_op == (VEC[v].dual ? 8'hBB : 8'h3B), "R2 opcode", m_op, VEC[v].dual ? 8'hBB : 8'h3B);
      chk(m_addr == VEC[v].a, VEC[v].dual ? "R4 address" : "R3 address", m_addr, VEC[v].a);
      if (VEC[v].dual) chk(m_mode == VEC[v].m, "R4 mode byte", m_mode, VEC[v].m);
      chk(m_rises == hdr + 4 * int'(VEC[v].n), "R8 clock count", m_rises, hdr + 4 * int'(VEC[v].n));
      chk(m_csf == 1, "R8 single select", m_csf, 1);
      chk(nvalid == int'(VEC[v].n), "R8 byte count", nvalid, VEC[v].n);
      for (int i = 0; i < int'(VEC[v].n) && i < nvalid; i++)
        if (got[i] != fbyte(VEC[v].a + 24'(i))) mism++;
      chk(mism == 0, "R5 data bytes", mism, 0);
      chk(m_conf == 0, "R6 released lanes", m_conf, 0);
      chk(hi_bad == 0, "R7 sclk high time", hi_bad, 0);
      chk(ndone == 1, "R9 done pulse", ndone, 1);
      chk(gap_len == GAP_CYC, "R9 cs high gap", gap_len, GAP_CYC);
      chk(cs_n === 1'b1 && sclk === 1'b0, "R7 idle after burst", {cs_n, sclk}, 2'b10);
    end

    // R9: request during a burst and during the gap is ignored
    clear_mon();
    start(1'b0, 24'h000100, 8'd3, 4'd1, 8'h00);
    repeat (30) @(negedge clk);
    addr = 24'h777777; nbytes = 8'd9; req = 1'b1;
    @(negedge clk); req = 1'b0;
    while (ndone == 0 && cyc < 140000) @(negedge clk);
    addr = 24'h333333; nbytes = 8'd2; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (60) @(negedge clk);
    chk(m_csf == 1, "R9 busy request ignored", m_csf, 1);
    chk(m_addr == 24'h000100, "R9 address kept", m_addr, 24'h000100);
    chk(nvalid == 3, "R9 byte count kept", nvalid, 3);
    chk(busy === 1'b0, "R9 idle again", busy, 0);

    // R10: zero-length request ignored
    clear_mon();
    start(1'b1, 24'h000010, 8'd0, 4'd0, 8'h00);
    begin
      int bseen = 0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (busy || !cs_n) bseen++;
      end
      chk(bseen == 0, "R10 no activity", bseen, 0);
    end
    chk(m_csf == 0 && ndone == 0, "R10 no select or done", m_csf + ndone, 0);

    // R1: reset in the middle of a burst
    clear_mon();
    start(1'b1, 24'h00ABCD, 8'd8, 4'd1, 8'h00);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && !io0_oe && !io1_oe && !busy,
        "R1 mid-burst reset", {cs_n, sclk, io0_oe, io1_oe, busy}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 after reset: a fresh burst still returns correct data
    clear_mon();
    start(1'b1, 24'h00ABCD, 8'd2, 4'd0, 8'h00);
    wait_idle();
    chk(nvalid == 2 && got[0] == fbyte(24'h00ABCD) && got[1] == fbyte(24'h00ABCE),
        "R5 burst after reset", got[0], fbyte(24'h00ABCD));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule